// File: doc/BRIEF.md
# Hold-And-Modify Bitplane Fade Engine

This block applies one darkening step to a group of horizontally adjacent pixels in an image held as six bitplanes. Two of the planes are control planes and the other four are data planes. Each pixel therefore has two control bits and four data bits, and the six planes together can show up to 4096 colours through 12-bit colour. The block ORs the two control words into a per-pixel mask. A mask bit of 0 means the pixel takes its colour from the base palette, so its data bits pass through unchanged. A mask bit of 1 means the pixel sets a red, green or blue level directly, and its 4-bit level is decremented by one.

The arithmetic is bit-sliced. All pixels of the group are decremented together. A borrow word starts equal to the mask and then ripples through the data planes, from the least significant plane to the most significant, one plane per clock. Any borrow left after the top plane marks pixels that underflowed, and those pixels are cleared to zero. Applying the step over and over therefore drives every directly-set level to black, where it stays. Both the input side and the output side use a valid/ready handshake.

Top module: `ham_fade_engine`

## Requirements
- R1: The mask bit of pixel i is control plane 0 bit i OR control plane 1 bit i. Control plane c, bit i is `in_ctrl[c*16+i]`. A pixel whose mask bit is 0 leaves the block with the same four data bits it came in with.
- R2: A pixel whose mask bit is 1 and whose 4-bit level v is not 0 leaves the block with level v-1.
- R3: A pixel whose mask bit is 1 and whose level is 0 underflows, and all four of its data bits leave the block as 0.
- R4: The level of pixel i is built from `in_data[k*16+i]` as bit k, with plane 0 least significant. The result uses the same layout on `out_data`.
- R5: A group is accepted on a clock edge where `in_valid` and `in_ready` are both high. `out_valid` goes high exactly four clock edges after that edge.
- R6: `in_ready` is high only while the block is idle. It is low from the acceptance edge until the result has been taken. Input presented while it is low is ignored.
- R7: Once `out_valid` is high, it and `out_data` stay unchanged until an edge where `out_ready` is high. That edge takes the result and returns the block to idle.
- R8: While synchronous active-high `rst` is applied, and right after it, `out_valid` is 0 and `in_ready` is 1.
- R9: When each result is fed back as the next input with the same control words, every mask-1 pixel reaches level 0 within 16 steps and stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input group present |
| in_ready | output | 1 | Block idle and able to accept a group |
| in_ctrl | input | 32 | Two control plane words, plane c at bits c*16 +: 16 |
| in_data | input | 64 | Four data plane words, plane k at bits k*16 +: 16 |
| out_valid | output | 1 | Faded group available |
| out_ready | input | 1 | Consumer takes the faded group |
| out_data | output | 64 | Faded data plane words, same layout as in_data |

## Verification
The assertions assume that the consumer may hold `out_ready` low for any length of time, and that `in_valid` may stay high while the block is busy. They place no demand on when the input words change, because the words are sampled only on the acceptance edge. The stimulus stalls the output side for several cycles and keeps `in_valid` high with unrelated words while a group is in progress, so those assumptions are actually exercised. The data patterns include all-palette groups, groups where every level 0..15 is present, single-control-plane masks, random groups, and a feedback run that walks every directly-set level down to zero.

// File: rtl/ham_fade_pkg.sv
package ham_fade_pkg;
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_RUN  = 2'd1,
      FS_DONE = 2'd2
   } fade_state_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/ham_mask_gen.sv
module ham_mask_gen #(
   parameter int unsigned PIX_W       = 16,
   parameter int unsigned CTRL_PLANES = 2
) (
   input  logic [CTRL_PLANES*PIX_W-1:0] ctrl_words,
   output logic [PIX_W-1:0]             direct_mask
);
   generate
      if (CTRL_PLANES < 1) begin : g_bad_ctrl
         $error("ham_mask_gen: CTRL_PLANES must be at least 1");
      end
      if (CTRL_PLANES == 1) begin : g_single
         assign direct_mask = ctrl_words;
      end else begin : g_multi
         logic [PIX_W-1:0] acc [CTRL_PLANES];
         assign acc[0] = ctrl_words[PIX_W-1:0];
         for (genvar c = 1; c < CTRL_PLANES; c++) begin : g_or
            assign acc[c] = acc[c-1] | ctrl_words[c*PIX_W +: PIX_W];
         end
         assign direct_mask = acc[CTRL_PLANES-1];
      end
   endgenerate
endmodule

// File: rtl/ham_borrow_slice.sv
module ham_borrow_slice #(
   parameter int unsigned PIX_W = 16
) (
   input  logic [PIX_W-1:0] plane_in,
   input  logic [PIX_W-1:0] borrow_in,
   output logic [PIX_W-1:0] plane_out,
   output logic [PIX_W-1:0] borrow_out
);
   // one bit-sliced subtract stage: each column subtracts its borrow bit
   assign plane_out  = plane_in ^ borrow_in;
   assign borrow_out = ~plane_in & borrow_in;
endmodule

// File: rtl/ham_fade_seq.sv
module ham_fade_seq
   import ham_fade_pkg::*;
#(
   parameter int unsigned DATA_PLANES = 4,
   localparam int unsigned IDX_W      = idx_width(DATA_PLANES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             out_ready,
   output logic             in_ready,
   output logic             out_valid,
   output logic             load,
   output logic             step,
   output logic [IDX_W-1:0] plane_idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_PLANES - 1);

   fade_state_e      state_q;
   logic [IDX_W-1:0] cnt_q;
   logic             at_last;

   assign at_last   = (cnt_q == LAST_IDX);
   assign in_ready  = (state_q == FS_IDLE);
   assign out_valid = (state_q == FS_DONE);
   assign load      = in_ready && in_valid;
   assign step      = (state_q == FS_RUN);
   assign plane_idx = cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= FS_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            FS_IDLE: if (in_valid) begin
               state_q <= FS_RUN;
               cnt_q   <= '0;
            end
            FS_RUN: if (at_last) begin
               state_q <= FS_DONE;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            FS_DONE: if (out_ready) state_q <= FS_IDLE;
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   // R6
   accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);
   // R6
   ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(in_ready && out_valid));
   // R5
   last_to_done_chk: assert property (@(posedge clk) disable iff (rst)
      (step && at_last) |=> out_valid);
   // R7
   hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> out_valid);
endmodule

// File: rtl/ham_fade_engine.sv
module ham_fade_engine
   import ham_fade_pkg::*;
#(
   parameter int unsigned PIX_W       = 16,
   parameter int unsigned CTRL_PLANES = 2,
   parameter int unsigned DATA_PLANES = 4,
   localparam int unsigned CTRL_W     = CTRL_PLANES * PIX_W,
   localparam int unsigned DATA_W     = DATA_PLANES * PIX_W,
   localparam int unsigned IDX_W      = idx_width(DATA_PLANES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CTRL_W-1:0] in_ctrl,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (PIX_W < 1) begin : g_bad_pix
         $error("ham_fade_engine: PIX_W must be at least 1");
      end
      if (DATA_PLANES < 1) begin : g_bad_data
         $error("ham_fade_engine: DATA_PLANES must be at least 1");
      end
   endgenerate

   logic             load, step;
   logic [IDX_W-1:0] plane_idx;
   logic [PIX_W-1:0] mask;
   logic [PIX_W-1:0] borrow_q;
   logic [PIX_W-1:0] plane_q [DATA_PLANES];
   logic [PIX_W-1:0] cur_plane, new_plane, new_borrow;

   ham_mask_gen #(.PIX_W(PIX_W), .CTRL_PLANES(CTRL_PLANES)) i_mask (
      .ctrl_words  (in_ctrl),
      .direct_mask (mask)
   );

   ham_fade_seq #(.DATA_PLANES(DATA_PLANES)) i_seq (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .load      (load),
      .step      (step),
      .plane_idx (plane_idx)
   );

   assign cur_plane = plane_q[plane_idx];

   ham_borrow_slice #(.PIX_W(PIX_W)) i_slice (
      .plane_in   (cur_plane),
      .borrow_in  (borrow_q),
      .plane_out  (new_plane),
      .borrow_out (new_borrow)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         borrow_q <= '0;
      end else if (load) begin
         borrow_q <= mask;
      end else if (step) begin
         borrow_q <= new_borrow;
      end
   end

   generate
      for (genvar k = 0; k < DATA_PLANES; k++) begin : g_plane
         always_ff @(posedge clk) begin
            if (rst) begin
               plane_q[k] <= '0;
            end else if (load) begin
               plane_q[k] <= in_data[k*PIX_W +: PIX_W];
            end else if (step && (plane_idx == IDX_W'(k))) begin
               plane_q[k] <= new_plane;
            end
         end
         // leftover borrow after the top plane marks underflowed pixels
         assign out_data[k*PIX_W +: PIX_W] = plane_q[k] & ~borrow_q;
      end
   endgenerate

   // R7
   data_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> $stable(out_data));
   // R2
   borrow_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
      step |=> ((borrow_q & ~$past(borrow_q)) == '0));
endmodule

// File: tb/test_ham_fade_engine.sv
module test_ham_fade_engine;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic        in_ready;
   logic [31:0] in_ctrl;
   logic [63:0] in_data;
   logic        out_valid;
   logic        out_ready;
   logic [63:0] out_data;

   int total = 0;
   int bad   = 0;

   // behavioural model state
   int          m_phase = 0;   // 0 idle, 1..4 running, 5 result held
   logic [63:0] m_exp;
   logic [31:0] m_ctrl_q;
   logic [63:0] m_in_q;
   bit          m_stalled = 0;

   always #2.5 clk = ~clk;

   ham_fade_engine i_ham_fade_engine (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_ctrl(in_ctrl), .in_data(in_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   function automatic logic [63:0] ref_step(input logic [31:0] c, input logic [63:0] d);
      logic [63:0] r = d;
      for (int i = 0; i < 16; i++) begin
         int v = d[i] + 2*d[16+i] + 4*d[32+i] + 8*d[48+i];
         if (c[i] | c[16+i]) v = (v == 0) ? 0 : v - 1;
         for (int k = 0; k < 4; k++) r[k*16+i] = v[k];
      end
      return r;
   endfunction

   task automatic check_bit(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%b exp=%b", tag, act, exp);
      end
   endtask

   task automatic check_data();
      total++;
      if (out_data !== m_exp) begin
         bad++;
         for (int i = 0; i < 16; i++) begin
            logic [3:0] a, e, s;
            a = {out_data[48+i], out_data[32+i], out_data[16+i], out_data[i]};
            e = {m_exp[48+i], m_exp[32+i], m_exp[16+i], m_exp[i]};
            s = {m_in_q[48+i], m_in_q[32+i], m_in_q[16+i], m_in_q[i]};
            if (a !== e) begin
               if (m_stalled)
                  $display("FAIL R7 pixel %0d changed during stall act=%h exp=%h", i, a, e);
               else if (!(m_ctrl_q[i] | m_ctrl_q[16+i]))
                  $display("FAIL R1 pixel %0d palette pass act=%h exp=%h", i, a, e);
               else if (s == 0)
                  $display("FAIL R3 pixel %0d underflow act=%h exp=%h", i, a, e);
               else
                  $display("FAIL R2 pixel %0d decrement act=%h exp=%h", i, a, e);
            end
         end
      end
   endtask

   // advance one clock with model prediction, then compare away from the edge
   task automatic tick();
      int nxt = m_phase;
      if (m_phase == 0 && in_valid) begin
         nxt = 1;
         m_ctrl_q = in_ctrl;
         m_in_q   = in_data;
         m_exp    = ref_step(in_ctrl, in_data);
      end else if (m_phase >= 1 && m_phase <= 4) begin
         nxt = m_phase + 1;
      end else if (m_phase == 5 && out_ready) begin
         nxt = 0;
      end
      m_stalled = (m_phase == 5 && nxt == 5);
      @(posedge clk);
      @(negedge clk);
      m_phase = nxt;
      check_bit("R6 in_ready", in_ready, m_phase == 0);
      check_bit("R5 out_valid", out_valid, m_phase == 5);
      if (m_phase == 5) check_data();
   endtask

   task automatic run_group(input logic [31:0] c, input logic [63:0] d,
                            input int stall, input bit noise,
                            output logic [63:0] res);
      in_ctrl  = c;
      in_data  = d;
      in_valid = 1'b1;
      out_ready = 1'b0;
      tick();
      // R6: input offered while busy must be ignored
      if (noise) begin
         in_ctrl = ~c;
         in_data = ~d;
      end else begin
         in_valid = 1'b0;
      end
      while (m_phase != 5) tick();
      for (int s = 0; s < stall; s++) tick();
      res = out_data;
      in_valid  = 1'b0;
      out_ready = 1'b1;
      tick();
      out_ready = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [63:0] r;
      logic [63:0] ramp;
      rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_ctrl = '0; in_data = '0;
      repeat (3) @(negedge clk);
      // R8 reset state
      check_bit("R8 out_valid in reset", out_valid, 1'b0);
      check_bit("R8 in_ready in reset", in_ready, 1'b1);
      rst = 1'b0;
      @(negedge clk);
      check_bit("R8 out_valid after reset", out_valid, 1'b0);
      check_bit("R8 in_ready after reset", in_ready, 1'b1);

      // ramp: pixel i holds level i (R4 layout)
      for (int i = 0; i < 16; i++)
         for (int k = 0; k < 4; k++) ramp[k*16+i] = i[k];

      // R1: all palette pixels pass through
      run_group(32'h0, 64'hDEAD_BEEF_0123_4567, 0, 0, r);
      // R2 R3: every level with direct mask
      run_group(32'h0000_FFFF, ramp, 0, 0, r);
      // R1: mask from control plane 1 only, half the pixels
      run_group(32'hF0F0_0000, ramp, 2, 1, r);
      // R7: long stall with noise on the input side (R6)
      run_group(32'h00FF_0F0F, 64'h1234_5678_9ABC_DEF0, 5, 1, r);
      // R3: all zero levels with full mask
      run_group(32'hFFFF_FFFF, 64'h0, 1, 0, r);
      for (int n = 0; n < 12; n++)
         run_group($urandom, {$urandom, $urandom}, n % 3, n[0], r);

      // R9: feedback walk to black
      begin
         logic [63:0] cur = 64'hFFFF_FFFF_FFFF_FFFF;
         for (int s = 0; s < 16; s++) begin
            run_group(32'h0000_A5A5, cur, 0, 0, r);
            cur = r;
         end
         total++;
         if ((cur & {4{16'hA5A5}}) !== 64'h0 || (cur & {4{16'h5A5A}}) !== {4{16'h5A5A}}) begin
            bad++;
            $display("FAIL R9 feedback result act=%h exp=%h", cur, {4{16'h5A5A}});
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule